// File: doc/BRIEF.md
# PLL Lock Detector with Output Select

This block watches two single-cycle pulse streams inside a frequency synthesizer: the divided reference pulse and the divided feedback (VCO) pulse. Both run in the reference-clock domain. For each pair of pulses it counts how many reference-clock cycles lie between them. A pair that lands within the threshold is a close comparison. A lock flag rises only after a run of close comparisons, and it falls at once on any comparison that is not close.

A three-bit select input picks what drives the single status pin. The pin can carry the lock flag or either pulse stream divided by two, or it can be held low. While the synthesizer is in standby, the pin is forced high and all detector state is cleared. The pin is registered, so it carries no glitches.

Top module: `pll_lock_monitor`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `ld_out` is 0, the lock flag is clear and both divide-by-two stages hold 0.
- R2: A comparison measures the number of `clk` cycles from the first pulse to the partner pulse. Either stream may lead. Pulses on the same cycle give an offset of 0.
- R3: An offset below `THRESH` (default 2 cycles) is close. The lock flag sets on the `MATCH_NEED`-th consecutive close comparison (default 4) and not on the one before it.
- R4: An offset of `THRESH` or more clears the run of close comparisons and drops the lock flag. Another `MATCH_NEED` close comparisons are then needed to relock.
- R5: A leading pulse with no partner within `MISS_LIMIT` cycles is a failed comparison with the same effect as R4. So is a second pulse from the leading stream that arrives before the partner.
- R6: With `ld_sel` = 3'b100, `ld_out` follows the lock flag, one register stage later.
- R7: With `ld_sel` = 3'b101, `ld_out` toggles once per feedback pulse. With `ld_sel` = 3'b110, it toggles once per reference pulse.
- R8: With `ld_sel[2]` = 0, or with `ld_sel` = 3'b111, `ld_out` is held 0. The lock flag is kept, so returning to 3'b100 shows it again.
- R9: With `standby` high, `ld_out` is 1 on the next cycle whatever `ld_sel` is. Standby clears the lock flag, the run count, the measurement and both divide-by-two stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| fr_pls | input | 1 | Divided reference pulse, one cycle wide |
| fv_pls | input | 1 | Divided feedback pulse, one cycle wide |
| standby | input | 1 | Standby request; clears the detector and forces the pin high |
| ld_sel | input | 3 | Status pin source select |
| ld_out | output | 1 | Registered status pin |

## Verification
The bench builds the block with `THRESH` = 2 and `MATCH_NEED` = 4 left at their defaults, and sets `MISS_LIMIT` to 12 against a 16-cycle pulse period. A missing partner therefore times out well inside one period, which makes both kinds of failed comparison reachable in a few hundred cycles. Offsets of -2, -1, 0, 1 and 2 cycles probe the threshold edge with each stream leading. Streams with one side only separate the two halved sources and exercise the timeout.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;
  localparam logic [2:0] SEL_LOCK = 3'b100;
  localparam logic [2:0] SEL_FVH  = 3'b101;
  localparam logic [2:0] SEL_FRH  = 3'b110;

  typedef enum logic [1:0] {
    PM_IDLE    = 2'd0,
    PM_WAIT_FV = 2'd1,
    PM_WAIT_FR = 2'd2
  } pm_state_t;
endpackage

// File: rtl/phase_meter.sv
module phase_meter
  import lockdet_pkg::*;
#(
  parameter int THRESH     = 2,
  parameter int MISS_LIMIT = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic fr_pls,
  input  logic fv_pls,
  output logic cmp_valid,
  output logic cmp_close
);
  localparam int CW = $clog2(MISS_LIMIT + 1);

  pm_state_t   st;
  logic [CW-1:0] cnt;
  logic        lead_hit, lag_hit;

  // In a wait state, lag is the partner pulse and lead is a repeat of the opener
  always_comb begin
    lead_hit = (st == PM_WAIT_FV) ? fr_pls : fv_pls;
    lag_hit  = (st == PM_WAIT_FV) ? fv_pls : fr_pls;
  end

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      st        <= PM_IDLE;
      cnt       <= '0;
      cmp_valid <= 1'b0;
      cmp_close <= 1'b0;
    end else begin
      cmp_valid <= 1'b0;
      cmp_close <= 1'b0;
      case (st)
        PM_IDLE: begin
          if (fr_pls && fv_pls) begin
            cmp_valid <= 1'b1;
            cmp_close <= (THRESH > 0);
          end else if (fr_pls) begin
            st  <= PM_WAIT_FV;
            cnt <= CW'(1);
          end else if (fv_pls) begin
            st  <= PM_WAIT_FR;
            cnt <= CW'(1);
          end
        end
        PM_WAIT_FV, PM_WAIT_FR: begin
          if (lag_hit) begin
            cmp_valid <= 1'b1;
            cmp_close <= (int'(cnt) < THRESH);
            st        <= PM_IDLE;
            cnt       <= '0;
          end else if (lead_hit) begin
            cmp_valid <= 1'b1;
            cmp_close <= 1'b0;
            cnt       <= CW'(1);
          end else if (cnt >= CW'(MISS_LIMIT)) begin
            cmp_valid <= 1'b1;
            cmp_close <= 1'b0;
            st        <= PM_IDLE;
            cnt       <= '0;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        default: begin
          st  <= PM_IDLE;
          cnt <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/lock_filter.sv
module lock_filter #(
  parameter int MATCH_NEED = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic cmp_valid,
  input  logic cmp_close,
  output logic locked
);
  localparam int RW = $clog2(MATCH_NEED + 1);

  logic [RW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      run    <= '0;
      locked <= 1'b0;
    end else if (cmp_valid) begin
      if (cmp_close) begin
        if (run < RW'(MATCH_NEED)) run <= run + RW'(1);
        if (run >= RW'(MATCH_NEED - 1)) locked <= 1'b1;
      end else begin
        run    <= '0;
        locked <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pulse_halver.sv
module pulse_halver (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic pls,
  output logic half
);
  always_ff @(posedge clk) begin
    if (rst || hold) half <= 1'b0;
    else if (pls)    half <= ~half;
  end
endmodule

// File: rtl/pll_lock_monitor.sv
module pll_lock_monitor
  import lockdet_pkg::*;
#(
  parameter int THRESH     = 2,
  parameter int MATCH_NEED = 4,
  parameter int MISS_LIMIT = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       fr_pls,
  input  logic       fv_pls,
  input  logic       standby,
  input  logic [2:0] ld_sel,
  output logic       ld_out
);
  localparam int NSRC = 2;

  logic            cmp_valid, cmp_close, locked;
  logic [NSRC-1:0] pls_vec, half_vec;
  logic            ld_q;

  assign pls_vec = {fv_pls, fr_pls};

  phase_meter #(.THRESH(THRESH), .MISS_LIMIT(MISS_LIMIT)) meter_i (
    .clk(clk), .rst(rst), .hold(standby),
    .fr_pls(fr_pls), .fv_pls(fv_pls),
    .cmp_valid(cmp_valid), .cmp_close(cmp_close)
  );

  lock_filter #(.MATCH_NEED(MATCH_NEED)) filt_i (
    .clk(clk), .rst(rst), .hold(standby),
    .cmp_valid(cmp_valid), .cmp_close(cmp_close), .locked(locked)
  );

  // index 0: reference stream, index 1: feedback stream
  for (genvar i = 0; i < NSRC; i++) begin : g_half
    pulse_halver half_i (
      .clk(clk), .rst(rst), .hold(standby),
      .pls(pls_vec[i]), .half(half_vec[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_q <= 1'b0;
    end else if (standby) begin
      ld_q <= 1'b1;
    end else begin
      case (ld_sel)
        SEL_LOCK: ld_q <= locked;
        SEL_FVH:  ld_q <= half_vec[1];
        SEL_FRH:  ld_q <= half_vec[0];
        default:  ld_q <= 1'b0;
      endcase
    end
  end

  assign ld_out = ld_q;
endmodule

// File: rtl/pll_lock_monitor_chk.sv
module pll_lock_monitor_chk (
  input logic       clk,
  input logic       rst,
  input logic       standby,
  input logic [2:0] ld_sel,
  input logic       ld_out,
  input logic       cmp_valid,
  input logic       cmp_close,
  input logic       locked
);
  a_r3_lock_needs_close: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(cmp_valid && cmp_close));

  a_r4_fail_drops_lock: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && !cmp_close) |=> !locked);

  a_r9_standby_pin_high: assert property (@(posedge clk) disable iff (rst)
    standby |=> ld_out);

  a_r9_standby_unlocks: assert property (@(posedge clk) disable iff (rst)
    standby |=> !locked);

  a_r8_disabled_low: assert property (@(posedge clk) disable iff (rst)
    (!standby && !ld_sel[2]) |=> !ld_out);

  a_r6_pin_tracks_lock: assert property (@(posedge clk) disable iff (rst)
    (!standby && ld_sel == 3'b100) |=> (ld_out == $past(locked)));
endmodule

bind pll_lock_monitor pll_lock_monitor_chk chk_i (
  .clk(clk), .rst(rst), .standby(standby), .ld_sel(ld_sel), .ld_out(ld_out),
  .cmp_valid(cmp_valid), .cmp_close(cmp_close), .locked(locked)
);

// File: tb/pll_lock_monitor_tb_top.sv
module pll_lock_monitor_tb_top;
  localparam int PER  = 16;
  localparam int MISS = 12;

  typedef struct {
    int    kind;
    int    exp;
    string tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fr_pls = 1'b0, fv_pls = 1'b0, standby = 1'b0;
  logic [2:0] ld_sel = 3'b100;
  logic       ld_out;

  int    checks = 0, errors = 0, toggles = 0;
  logic  prev_ld = 1'b0;
  bit    finished = 1'b0;
  item_t q[$];

  always #2.5 clk = ~clk;

  pll_lock_monitor #(.THRESH(2), .MATCH_NEED(4), .MISS_LIMIT(MISS)) dut_i (
    .clk(clk), .rst(rst), .fr_pls(fr_pls), .fv_pls(fv_pls),
    .standby(standby), .ld_sel(ld_sel), .ld_out(ld_out)
  );

  always @(negedge clk) begin
    if (ld_out !== prev_ld) toggles++;
    prev_ld = ld_out;
  end

  // monitor: pops expected items and compares
  initial begin
    forever begin
      wait (q.size() > 0);
      @(negedge clk);
      #1;
      begin
        item_t it;
        int    act;
        it  = q.pop_front();
        act = (it.kind == 0) ? int'(ld_out) : toggles;
        checks++;
        if (act != it.exp) begin
          errors++;
          $display("FAIL %s actual %0d expected %0d", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic expect_item(int kind, int exp, string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    q.push_back(it);
    wait (q.size() == 0);
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_toggles();
    @(negedge clk);
    #1 toggles = 0;
  endtask

  // off > 0: reference leads by off cycles; off < 0: feedback leads
  task automatic run_periods(int n, int off, bit use_fr, bit use_fv);
    int a, b;
    a = (off >= 0) ? 0 : -off;
    b = (off >= 0) ? off : 0;
    for (int p = 0; p < n; p++) begin
      for (int k = 0; k < PER; k++) begin
        @(negedge clk);
        fr_pls = use_fr && (k == a);
        fv_pls = use_fv && (k == b);
      end
    end
    @(negedge clk);
    fr_pls = 1'b0;
    fv_pls = 1'b0;
    idle(3);
  endtask

  initial begin
    idle(5);
    expect_item(0, 0, "R1 pin low in reset");
    rst = 1'b0;
    @(negedge clk);
    expect_item(0, 0, "R1 pin low after reset");

    run_periods(3, 1, 1, 1);
    expect_item(0, 0, "R3 three close comparisons not enough");
    run_periods(1, 1, 1, 1);
    expect_item(0, 1, "R3 lock on fourth close comparison");

    run_periods(1, 2, 1, 1);
    expect_item(0, 0, "R4 offset 2 drops lock");
    run_periods(3, -1, 1, 1);
    expect_item(0, 0, "R4 run restarts after failure");
    run_periods(1, -1, 1, 1);
    expect_item(0, 1, "R2 feedback leading by 1 is close");
    run_periods(1, -2, 1, 1);
    expect_item(0, 0, "R4 feedback leading by 2 fails");
    run_periods(4, 0, 1, 1);
    expect_item(0, 1, "R2 same-cycle pulses count as close");

    run_periods(2, 0, 1, 0);
    expect_item(0, 0, "R5 missing feedback pulse fails");
    run_periods(4, 1, 1, 1);
    expect_item(0, 1, "R6 relock shows on pin");
    run_periods(1, 0, 0, 1);
    expect_item(0, 0, "R5 missing reference pulse fails");
    run_periods(4, 1, 1, 1);

    ld_sel = 3'b000; idle(3);
    expect_item(0, 0, "R8 select 000 holds pin low");
    ld_sel = 3'b111; idle(3);
    expect_item(0, 0, "R8 select 111 holds pin low");
    ld_sel = 3'b100; idle(3);
    expect_item(0, 1, "R6 lock kept while pin disabled");

    ld_sel = 3'b101; idle(3); clear_toggles();
    run_periods(3, 0, 0, 1);
    expect_item(1, 3, "R7 feedback half toggles per feedback pulse");
    ld_sel = 3'b110; idle(3); clear_toggles();
    run_periods(3, 0, 0, 1);
    expect_item(1, 0, "R7 reference half ignores feedback pulses");
    clear_toggles();
    run_periods(3, 0, 1, 0);
    expect_item(1, 3, "R7 reference half toggles per reference pulse");

    ld_sel = 3'b100; idle(2);
    run_periods(4, 1, 1, 1);
    ld_sel = 3'b000;
    standby = 1'b1; idle(2);
    expect_item(0, 1, "R9 standby forces pin high");
    ld_sel = 3'b100;
    standby = 1'b0; idle(3);
    expect_item(0, 0, "R9 standby cleared lock");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule